// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the card bus clock from the fixed input clock. Two counter stages are chained. The first is a prescaler that either passes every input cycle through or divides by twice its setting. The second is a small integer divider that divides the prescaler output by its setting plus one. Both settings share one rate word, which is written with a single strobe. A separate control word, written with its own strobe, starts or stops the clock and can issue a soft reset that returns the block to its idle state.

The output is in the input clock domain. `card_tick` is a one-cycle pulse that marks the end of each card clock period, and `card_clk` is the level form of the same clock. It is low for the first part of each period and high for the rest. Start, stop and rate changes act only at period boundaries, where the level is low, so the card never sees a shortened pulse. `clk_running` reports whether the card clock is active.

Top module: `card_clk_gen`

## Requirements
- R1: After `rst_n` is released, `clk_running` and `card_clk` are low, no `card_tick` occurs, and the active rate word is 0x0001 (prescaler 0, divider 1).
- R2: Rate word: bits 3:0 hold the divider D and bits 15:4 hold the prescaler P. While running, consecutive `card_tick` pulses are N = (D+1) × M input cycles apart, where M = 1 if P = 0 and M = 2P otherwise. The legal values of P are 0 and the powers of two up to 0x800.
- R3: A divider field of 0 behaves as a divider of 1.
- R4: The shortest period is 2 input cycles (P=0, D=1). The longest is 65536 input cycles (P=0x800, D=15).
- R5: Control word: bit 0 is stop, bit 1 is start, bit 3 is soft reset. A start write to a stopped block sets `clk_running` at the next edge, and the first `card_tick` comes N cycles after the write edge. `card_clk` is low in the first cycle. A start write to a running block does not restart or shift the period.
- R6: A stop write leaves `clk_running` high until the end of the current period. It falls on the edge that ends the period, and no tick follows. Stop wins over start when both bits are in the same write.
- R7: A rate write while running does not change the current period. The new rate applies from the next period onward.
- R8: A rate write while stopped takes effect at once and does not start the clock.
- R9: A control write with bit 3 set clears `clk_running` and `card_clk` at the next edge, restores rate 0x0001, and ignores the start and stop bits of the same write. The sequence reset, reset+start, then eight starts leaves the clock running at the default rate.
- R10: Within each period, `card_clk` is low for the first floor((D'+1)/2) divider steps and high for the rest, where D' is the effective divider. That is (D'+1 − floor((D'+1)/2)) × M high cycles per period. `card_clk` falls only on the edge after a `card_tick` or after a soft reset.
- R11: `card_tick` lasts exactly one cycle and occurs only while `clk_running` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Write strobe for the rate word |
| ctrl_wr | input | 1 | Write strobe for the control word |
| wdata | input | 16 | Write data shared by both strobes |
| card_clk | output | 1 | Card clock level |
| card_tick | output | 1 | One-cycle pulse at the end of each card clock period |
| clk_running | output | 1 | High while the card clock is active |

## Verification
A wrong prescaler or divider count shows up within one output period as a tick spacing or high-phase length that differs from the product formula. For the slowest setting this takes up to 65536 cycles. A pending stop or pending rate that is applied in the wrong cycle shows up within one period: either the period in progress changes length, or `clk_running` falls away from a tick. A soft reset that fails to clear the rate shows up as a wrong spacing in the first period after the restart sequence.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  // control word bit positions
  localparam int CTL_STOP  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_RST   = 3;

  // effective divider: a zero field acts as one
  function automatic int unsigned ckg_steps(input int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

  // number of low divider steps at the start of a period
  function automatic int unsigned ckg_low_steps(input int unsigned d);
    return (ckg_steps(d) + 1) / 2;
  endfunction
endpackage

// File: rtl/ckg_regs.sv
module ckg_regs #(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4,
  parameter int unsigned RESET_RATE = 1,
  localparam int RATE_W = PRE_W + DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic              ctrl_wr,
  input  logic [RATE_W-1:0] wdata,
  input  logic              period_end,
  output logic              run,
  output logic [RATE_W-1:0] act_rate,
  output logic              soft_rst
);
  import ckg_pkg::*;

  logic [RATE_W-1:0] pend_rate;
  logic              pend_v;
  logic              stop_p;
  logic              ctl_start;
  logic              ctl_stop;

  assign soft_rst  = ctrl_wr & wdata[CTL_RST];
  assign ctl_stop  = ctrl_wr & wdata[CTL_STOP] & ~wdata[CTL_RST];
  assign ctl_start = ctrl_wr & wdata[CTL_START] & ~wdata[CTL_STOP] & ~wdata[CTL_RST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      act_rate  <= RATE_W'(RESET_RATE);
      pend_rate <= '0;
      pend_v    <= 1'b0;
      stop_p    <= 1'b0;
    end else if (soft_rst) begin
      run       <= 1'b0;
      act_rate  <= RATE_W'(RESET_RATE);
      pend_rate <= '0;
      pend_v    <= 1'b0;
      stop_p    <= 1'b0;
    end else begin
      // rate word: immediate when idle, at the period boundary when running
      if (!run) begin
        if (rate_wr) act_rate <= wdata;
        pend_v <= 1'b0;
      end else if (period_end) begin
        if (rate_wr)     act_rate <= wdata;
        else if (pend_v) act_rate <= pend_rate;
        pend_v <= 1'b0;
      end else if (rate_wr) begin
        pend_rate <= wdata;
        pend_v    <= 1'b1;
      end
      // run state: start at once (counters idle low), stop at the boundary
      if (!run) begin
        if (ctl_start) run <= 1'b1;
        stop_p <= 1'b0;
      end else if (period_end && (stop_p || ctl_stop)) begin
        run    <= 1'b0;
        stop_p <= 1'b0;
      end else if (ctl_stop) begin
        stop_p <= 1'b1;
      end else if (ctl_start) begin
        stop_p <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ckg_prescale.sv
module ckg_prescale #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_val,
  output logic             pre_tick
);
  logic [PRE_W:0] cnt;
  logic [PRE_W:0] limit;
  logic           bypass;
  logic           at_limit;

  assign bypass   = (pre_val == '0);
  assign limit    = {pre_val, 1'b0} - 1'b1;
  assign at_limit = (cnt == limit);
  assign pre_tick = run & (bypass | at_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || bypass)    cnt <= '0;
    else if (at_limit)          cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ckg_divide.sv
module ckg_divide #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             card_clk,
  output logic             period_end
);
  import ckg_pkg::*;

  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W-1:0] lo_steps;

  assign d_eff      = DIV_W'(ckg_steps(32'(div_val)));
  assign lo_steps   = DIV_W'(ckg_low_steps(32'(div_val)));
  assign period_end = pre_tick & (dcnt == d_eff);
  assign card_clk   = run & (dcnt >= lo_steps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dcnt <= '0;
    else if (!run)       dcnt <= '0;
    else if (period_end) dcnt <= '0;
    else if (pre_tick)   dcnt <= dcnt + 1'b1;
  end
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int PRE_W = 12,
  parameter int DIV_W = 4,
  parameter int unsigned RESET_RATE = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rate_wr,
  input  logic                   ctrl_wr,
  input  logic [PRE_W+DIV_W-1:0] wdata,
  output logic                   card_clk,
  output logic                   card_tick,
  output logic                   clk_running
);
  localparam int RATE_W = PRE_W + DIV_W;

  logic              run;
  logic [RATE_W-1:0] act_rate;
  logic              soft_rst;
  logic              pre_tick;
  logic              period_end;

  ckg_regs #(.PRE_W(PRE_W), .DIV_W(DIV_W), .RESET_RATE(RESET_RATE)) u_regs (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .ctrl_wr(ctrl_wr),
    .wdata(wdata), .period_end(period_end), .run(run),
    .act_rate(act_rate), .soft_rst(soft_rst)
  );

  ckg_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run),
    .pre_val(act_rate[RATE_W-1:DIV_W]), .pre_tick(pre_tick)
  );

  ckg_divide #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_tick(pre_tick),
    .div_val(act_rate[DIV_W-1:0]), .card_clk(card_clk),
    .period_end(period_end)
  );

  assign card_tick   = period_end;
  assign clk_running = run;
endmodule

// File: rtl/card_clk_gen_chk.sv
module card_clk_gen_chk #(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic [RATE_W-1:0] wdata,
  input logic              card_clk,
  input logic              card_tick,
  input logic              clk_running,
  input logic              pre_tick,
  input logic              soft_rst,
  input logic [RATE_W-1:0] act_rate
);
  import ckg_pkg::*;

  a_r11_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    card_tick |-> clk_running);

  a_r11_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
    card_tick |=> !card_tick);

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_running |-> !card_clk);

  a_r2_prescale_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> clk_running);

  a_r6_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_running) |-> ($past(card_tick) || $past(ctrl_wr && wdata[CTL_RST])));

  a_r10_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk) |-> ($past(card_tick) || $past(ctrl_wr && wdata[CTL_RST])));

  a_r5_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_running) |-> $past(ctrl_wr && wdata[CTL_START]
                                 && !wdata[CTL_STOP] && !wdata[CTL_RST]));

  a_r7_rate_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_running && $past(clk_running) && !$stable(act_rate)) |-> $past(card_tick));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !clk_running);
endmodule

bind card_clk_gen card_clk_gen_chk #(.RATE_W(PRE_W + DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(wdata),
  .card_clk(card_clk), .card_tick(card_tick), .clk_running(clk_running),
  .pre_tick(pre_tick), .soft_rst(soft_rst), .act_rate(act_rate)
);

// File: tb/card_clk_gen_bench.sv
`timescale 1ns/1ps
module card_clk_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_wr = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [15:0] wdata = '0;
  logic        card_clk, card_tick, clk_running;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  card_clk_gen u_card_clk_gen (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .ctrl_wr(ctrl_wr),
    .wdata(wdata), .card_clk(card_clk), .card_tick(card_tick),
    .clk_running(clk_running)
  );

  // expected spacing from the rate word
  function automatic int exp_period(input logic [15:0] r);
    int d = (r[3:0] == 0) ? 1 : int'(r[3:0]);
    int p = int'(r[15:4]);
    int m = (p == 0) ? 1 : 2 * p;
    return (d + 1) * m;
  endfunction

  function automatic int exp_high(input logic [15:0] r);
    int d = (r[3:0] == 0) ? 1 : int'(r[3:0]);
    int p = int'(r[15:4]);
    int m = (p == 0) ? 1 : 2 * p;
    return ((d + 1) - (d + 1) / 2) * m;
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit is_ctrl, input logic [15:0] v);
    @(negedge clk);
    rate_wr = !is_ctrl; ctrl_wr = is_ctrl; wdata = v;
    @(negedge clk);
    rate_wr = 1'b0; ctrl_wr = 1'b0;
  endtask

  task automatic wait_tick();
    while (!card_tick) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    wait_tick();
    per = 0; hi = 0;
    do begin
      @(negedge clk);
      per++;
      hi += int'(card_clk);
    end while (!card_tick);
  endtask

  task automatic start_latency(output int c);
    c = 1;
    while (!card_tick) begin @(negedge clk); c++; end
  endtask

  task automatic set_rate_measure(input logic [15:0] r, input string req);
    int per, hi;
    wr(0, r);
    wait_tick(); @(negedge clk); wait_tick();
    measure(per, hi);
    chk(per, exp_period(r), {req, " period"});
    chk(hi, exp_high(r), "R10 high phase");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int per, hi, c, ticks;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    ticks = 0;
    repeat (10) begin @(negedge clk); ticks += int'(card_tick); end
    chk(int'(clk_running), 0, "R1 running after reset");
    chk(int'(card_clk), 0, "R1 card_clk after reset");
    chk(ticks, 0, "R1 no ticks idle");
    // R5 start at default rate, first tick latency
    wr(1, 16'h0002);
    chk(int'(card_clk), 0, "R5 low phase at start");
    start_latency(c);
    chk(c, 2, "R1 default rate latency");
    measure(per, hi);
    chk(per, 2, "R4 fastest period");
    chk(hi, 1, "R10 fastest high");
    // R3 divider zero
    set_rate_measure(16'h0000, "R3");
    // R7 change while running
    set_rate_measure(16'h0005, "R2");
    wait_tick();
    @(negedge clk); rate_wr = 1'b1; wdata = 16'h0013; c = 1;
    @(negedge clk); rate_wr = 1'b0; c = 2;
    while (!card_tick) begin @(negedge clk); c++; end
    chk(c, 6, "R7 old period kept");
    measure(per, hi);
    chk(per, 8, "R7 new period");
    // R5 start while running has no effect
    @(negedge clk); ctrl_wr = 1'b1; wdata = 16'h0002; c = 1;
    @(negedge clk); ctrl_wr = 1'b0; c = 2;
    while (!card_tick) begin @(negedge clk); c++; end
    chk(c, 8, "R5 start while running");
    // R6 stop at boundary
    wr(1, 16'h0001);
    chk(int'(clk_running), 1, "R6 running until boundary");
    wait_tick(); @(negedge clk);
    chk(int'(clk_running), 0, "R6 stopped after tick");
    ticks = 0;
    repeat (40) begin @(negedge clk); ticks += int'(card_tick) + int'(card_clk); end
    chk(ticks, 0, "R6 silent after stop");
    // R8 rate while stopped, then start latency
    wr(0, 16'h0004);
    chk(int'(clk_running), 0, "R8 rate write does not start");
    wr(1, 16'h0002);
    start_latency(c);
    chk(c, 5, "R8 rate applied at start");
    measure(per, hi);
    chk(hi, 3, "R10 high D=4");
    // R6 stop wins over start
    wr(1, 16'h0003);
    wait_tick(); @(negedge clk);
    chk(int'(clk_running), 0, "R6 stop wins");
    // R2 random settings
    wr(1, 16'h0002);
    for (int i = 0; i < 24; i++) begin
      int idx = int'($urandom % 6);
      int p = (idx == 0) ? 0 : (1 << (idx - 1));
      logic [15:0] r = {12'(p), 4'($urandom % 16)};
      set_rate_measure(r, "R2 random");
    end
    // R4 slowest, restarted from reset state
    wr(1, 16'h0008);
    wr(0, 16'h800F);
    wr(1, 16'h0002);
    start_latency(c);
    chk(c, 65536, "R4 slowest period");
    // R9 soft reset while running
    wr(1, 16'h000A);
    chk(int'(clk_running), 0, "R9 reset clears running");
    chk(int'(card_clk), 0, "R9 reset clears card_clk");
    wr(1, 16'h0008);
    wr(1, 16'h000A);
    chk(int'(clk_running), 0, "R9 start ignored with reset");
    for (int k = 0; k < 8; k++) wr(1, 16'h0002);
    chk(int'(clk_running), 1, "R9 running after sequence");
    measure(per, hi);
    chk(per, 2, "R9 default rate restored");
    measure(per, hi);
    chk(per, 2, "R11 steady ticks");
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule